// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block is the hazard control for a five-stage in-order pipeline made up of fetch, decode, execute, memory and writeback stages. It is purely combinational. Each cycle it reads the register fields held in the pipeline registers and returns a source choice for each of the two ALU operands. It also returns the hold and discard controls that the datapath applies at the next clock edge.

Operand forwarding takes a result from the instruction one stage ahead, in the memory stage, or from the instruction two stages ahead, in writeback. The closer producer wins when both match. A load in execute whose destination is read by the instruction in decode freezes the PC and the decode register for one cycle and zeroes the controls that enter execute. A taken branch resolved in the memory stage discards the three younger instructions in fetch, decode and execute. A register written in writeback and read in decode during the same cycle gets no special handling, because the register file returns the new value.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `fwd_a_o` is 2'b10 when `exmem_we_i` is 1, `exmem_rd_i` is nonzero and `exmem_rd_i` equals `idex_rs_i`.
- R2: `fwd_a_o` is 2'b01 when the R1 condition does not hold, `memwb_we_i` is 1, `memwb_rd_i` is nonzero and `memwb_rd_i` equals `idex_rs_i`.
- R3: When the memory-stage producer and the writeback producer both match an operand, the select is 2'b10, so the memory stage has priority.
- R4: `fwd_b_o` follows the same rules as R1 to R3, applied to `idex_rt_i`. The code 2'b11 never appears on either select.
- R5: A select is 2'b00 (register file) when neither producer matches, when the producer's write enable is 0, or when the producer's destination is register 0.
- R6: A load-use hazard exists when `idex_memrd_i` is 1 and `idex_rt_i` equals `ifid_rs_i` or `ifid_rt_i`. With no taken branch, a load-use hazard sets `stall_o` and `flush_id_o` to 1 and sets `pc_we_o` and `ifid_we_o` to 0.
- R7: A load-use stall discards only the decode-stage instruction: `flush_if_o` and `flush_ex_o` stay 0.
- R8: When `br_taken_i` is 1, all three flush outputs are 1, `stall_o` is 0, and `pc_we_o` and `ifid_we_o` are 1, even if a load-use hazard is present at the same time.
- R9: With no load-use hazard and no taken branch, `stall_o` and all flushes are 0 and both write enables are 1. A register match with `idex_memrd_i` at 0 causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs_i | input | REG_AW | First source register of the instruction in decode |
| ifid_rt_i | input | REG_AW | Second source register of the instruction in decode |
| idex_rs_i | input | REG_AW | First source register of the instruction in execute |
| idex_rt_i | input | REG_AW | Second source register, or load destination, of the instruction in execute |
| idex_memrd_i | input | 1 | Instruction in execute reads memory |
| exmem_rd_i | input | REG_AW | Destination register of the instruction in the memory stage |
| exmem_we_i | input | 1 | Register write enable of the memory-stage instruction |
| memwb_rd_i | input | REG_AW | Destination register of the instruction in writeback |
| memwb_we_i | input | 1 | Register write enable of the writeback instruction |
| br_taken_i | input | 1 | Branch resolved taken in the memory stage |
| fwd_a_o | output | 2 | First ALU operand source: 00 register file, 10 memory stage, 01 writeback |
| fwd_b_o | output | 2 | Second ALU operand source, same encoding |
| stall_o | output | 1 | Load-use stall in effect |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Decode pipeline register write enable |
| flush_if_o | output | 1 | Discard the instruction in fetch |
| flush_id_o | output | 1 | Discard the instruction in decode by zeroing the controls entering execute |
| flush_ex_o | output | 1 | Discard the instruction in execute |

## Verification
Every output is a combinational function of the current inputs. Each result is therefore due in the same cycle as its stimulus, with no register in the path. The bench changes inputs on the falling edge and compares all outputs with its behavioural model on the next rising edge, so the inputs have been stable for half a period when they are sampled. Directed cases cover each forwarding combination, the load-use hazard on each source field, and a branch arriving together with a load-use hazard. A long run of random fields drawn from a small register range then produces frequent matches and keeps every rule exercised.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_mux.sv
module hz_fwd_mux
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_we_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_we_i,
  output fwd_sel_e          sel_o
);
  logic mem_hit, wb_hit;

  // register 0 is hardwired; never a forwarding source
  assign mem_hit = exmem_we_i && (exmem_rd_i != '0) && (exmem_rd_i == src_i);
  assign wb_hit  = memwb_we_i && (memwb_rd_i != '0) && (memwb_rd_i == src_i);

  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0][REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0]              exmem_rd_i,
  input  logic                           exmem_we_i,
  input  logic [REG_AW-1:0]              memwb_rd_i,
  input  logic                           memwb_we_i,
  output logic [NUM_OPS-1:0][1:0]        sel_o
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_sel_e sel;
    hz_fwd_mux #(.REG_AW(REG_AW)) u_mux (
      .src_i      (src_i[g]),
      .exmem_rd_i (exmem_rd_i),
      .exmem_we_i (exmem_we_i),
      .memwb_rd_i (memwb_rd_i),
      .memwb_we_i (memwb_we_i),
      .sel_o      (sel)
    );
    assign sel_o[g] = sel;
  end
endmodule

// File: rtl/hz_loaduse_det.sv
module hz_loaduse_det #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                           ld_i,
  input  logic [REG_AW-1:0]              ld_rd_i,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] src_i,
  output logic                           hit_o
);
  logic [NUM_SRC-1:0] match;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign match[g] = (ld_rd_i == src_i[g]);
  end

  assign hit_o = ld_i && (|match);
endmodule

// File: rtl/hz_flush_ctrl.sv
module hz_flush_ctrl (
  input  logic ld_hit_i,
  input  logic br_taken_i,
  output logic stall_o,
  output logic pc_we_o,
  output logic ifid_we_o,
  output logic flush_if_o,
  output logic flush_id_o,
  output logic flush_ex_o
);
  // taken branch wins: PC must load the target, stalled instr is discarded anyway
  always_comb begin
    stall_o    = 1'b0;
    pc_we_o    = 1'b1;
    ifid_we_o  = 1'b1;
    flush_if_o = 1'b0;
    flush_id_o = 1'b0;
    flush_ex_o = 1'b0;
    if (br_taken_i) begin
      flush_if_o = 1'b1;
      flush_id_o = 1'b1;
      flush_ex_o = 1'b1;
    end else if (ld_hit_i) begin
      stall_o    = 1'b1;
      pc_we_o    = 1'b0;
      ifid_we_o  = 1'b0;
      flush_id_o = 1'b1;
    end
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ifid_rs_i,
  input  logic [REG_AW-1:0] ifid_rt_i,
  input  logic [REG_AW-1:0] idex_rs_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic              idex_memrd_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_we_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_we_i,
  input  logic              br_taken_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              stall_o,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              flush_if_o,
  output logic              flush_id_o,
  output logic              flush_ex_o
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][REG_AW-1:0] ex_src;
  logic [NUM_OPS-1:0][REG_AW-1:0] id_src;
  logic [NUM_OPS-1:0][1:0]        fwd_sel;
  logic                           ld_hit;

  assign ex_src = {idex_rt_i, idex_rs_i};
  assign id_src = {ifid_rt_i, ifid_rs_i};

  hz_fwd_unit #(.REG_AW(REG_AW), .NUM_OPS(NUM_OPS)) u_fwd (
    .src_i      (ex_src),
    .exmem_rd_i (exmem_rd_i),
    .exmem_we_i (exmem_we_i),
    .memwb_rd_i (memwb_rd_i),
    .memwb_we_i (memwb_we_i),
    .sel_o      (fwd_sel)
  );

  assign fwd_a_o = fwd_sel[0];
  assign fwd_b_o = fwd_sel[1];

  hz_loaduse_det #(.REG_AW(REG_AW), .NUM_SRC(NUM_OPS)) u_lu (
    .ld_i    (idex_memrd_i),
    .ld_rd_i (idex_rt_i),
    .src_i   (id_src),
    .hit_o   (ld_hit)
  );

  hz_flush_ctrl u_flush (
    .ld_hit_i   (ld_hit),
    .br_taken_i (br_taken_i),
    .stall_o    (stall_o),
    .pc_we_o    (pc_we_o),
    .ifid_we_o  (ifid_we_o),
    .flush_if_o (flush_if_o),
    .flush_id_o (flush_id_o),
    .flush_ex_o (flush_ex_o)
  );
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ifid_rs_i,
  input logic [REG_AW-1:0] ifid_rt_i,
  input logic [REG_AW-1:0] idex_rs_i,
  input logic [REG_AW-1:0] idex_rt_i,
  input logic              idex_memrd_i,
  input logic [REG_AW-1:0] exmem_rd_i,
  input logic              exmem_we_i,
  input logic [REG_AW-1:0] memwb_rd_i,
  input logic              memwb_we_i,
  input logic              br_taken_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic              stall_o,
  input logic              pc_we_o,
  input logic              ifid_we_o,
  input logic              flush_if_o,
  input logic              flush_id_o,
  input logic              flush_ex_o
);
  always_comb begin
    assert_fwd_code_R4: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11);
    if (fwd_a_o == 2'b10)
      assert_mem_src_R1: assert (exmem_we_i && exmem_rd_i != '0 && exmem_rd_i == idex_rs_i);
    if (fwd_a_o == 2'b01)
      assert_wb_src_R2: assert (memwb_we_i && memwb_rd_i != '0 && memwb_rd_i == idex_rs_i);
    if (fwd_b_o == 2'b01)
      assert_mem_prio_R3: assert (!(exmem_we_i && exmem_rd_i != '0 && exmem_rd_i == idex_rt_i));
    if (!exmem_we_i && !memwb_we_i)
      assert_no_fwd_R5: assert (fwd_a_o == 2'b00 && fwd_b_o == 2'b00);
    if (stall_o)
      assert_stall_ctl_R6: assert (!pc_we_o && !ifid_we_o && flush_id_o && idex_memrd_i);
    if (stall_o)
      assert_stall_narrow_R7: assert (!flush_if_o && !flush_ex_o);
    if (br_taken_i)
      assert_branch_R8: assert (flush_if_o && flush_id_o && flush_ex_o && !stall_o && pc_we_o);
    if (!idex_memrd_i && !br_taken_i)
      assert_quiet_R9: assert (!stall_o && !flush_id_o && pc_we_o && ifid_we_o);
  end
endmodule

bind pipe_hazard_ctrl hz_checker #(.REG_AW(REG_AW)) u_chk (
  .ifid_rs_i    (ifid_rs_i),
  .ifid_rt_i    (ifid_rt_i),
  .idex_rs_i    (idex_rs_i),
  .idex_rt_i    (idex_rt_i),
  .idex_memrd_i (idex_memrd_i),
  .exmem_rd_i   (exmem_rd_i),
  .exmem_we_i   (exmem_we_i),
  .memwb_rd_i   (memwb_rd_i),
  .memwb_we_i   (memwb_we_i),
  .br_taken_i   (br_taken_i),
  .fwd_a_o      (fwd_a_o),
  .fwd_b_o      (fwd_b_o),
  .stall_o      (stall_o),
  .pc_we_o      (pc_we_o),
  .ifid_we_o    (ifid_we_o),
  .flush_if_o   (flush_if_o),
  .flush_id_o   (flush_id_o),
  .flush_ex_o   (flush_ex_o)
);

// File: tb/sim_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_hazard_ctrl;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd;
  logic idex_memrd, exmem_we, memwb_we, br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic stall, pc_we, ifid_we, fl_if, fl_id, fl_ex;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  pipe_hazard_ctrl #(.REG_AW(AW)) u0 (
    .ifid_rs_i(ifid_rs), .ifid_rt_i(ifid_rt),
    .idex_rs_i(idex_rs), .idex_rt_i(idex_rt), .idex_memrd_i(idex_memrd),
    .exmem_rd_i(exmem_rd), .exmem_we_i(exmem_we),
    .memwb_rd_i(memwb_rd), .memwb_we_i(memwb_we), .br_taken_i(br_taken),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .pc_we_o(pc_we),
    .ifid_we_o(ifid_we), .flush_if_o(fl_if), .flush_id_o(fl_id), .flush_ex_o(fl_ex)
  );

  // behavioural reference
  function automatic int ref_fwd(int src);
    if (exmem_we && int'(exmem_rd) != 0 && int'(exmem_rd) == src) return 2;
    if (memwb_we && int'(memwb_rd) != 0 && int'(memwb_rd) == src) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit lu;
    int st;
    lu = idex_memrd && (idex_rt == ifid_rs || idex_rt == ifid_rt);
    st = (lu && !br_taken) ? 1 : 0;
    chk("R1 R2 R3 R5 fwd_a", int'(fwd_a), ref_fwd(int'(idex_rs)));
    chk("R4 fwd_b", int'(fwd_b), ref_fwd(int'(idex_rt)));
    chk("R6 R8 R9 stall", int'(stall), st);
    chk("R6 R8 R9 pc_we", int'(pc_we), 1 - st);
    chk("R6 R8 R9 ifid_we", int'(ifid_we), 1 - st);
    chk("R7 R8 flush_if", int'(fl_if), int'(br_taken));
    chk("R6 R8 flush_id", int'(fl_id), (br_taken || st) ? 1 : 0);
    chk("R7 R8 flush_ex", int'(fl_ex), int'(br_taken));
  endtask

  task automatic drive(int a, int b, int c, int d, int mr, int er, int ew,
                       int wr, int ww, int br);
    @(negedge clk);
    ifid_rs = AW'(a); ifid_rt = AW'(b); idex_rs = AW'(c); idex_rt = AW'(d);
    idex_memrd = mr[0]; exmem_rd = AW'(er); exmem_we = ew[0];
    memwb_rd = AW'(wr); memwb_we = ww[0]; br_taken = br[0];
    @(posedge clk);
    compare_all();
  endtask

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_ni = 1'b1;
    // reset-like idle state
    chk("R9 idle fwd_a", int'(fwd_a), 0);
    chk("R9 idle pc_we", int'(pc_we), 1);
    // R1 memory-stage forward on operand A
    drive(1, 2, 3, 4, 0, 3, 1, 0, 0, 0);
    chk("R1 direct", int'(fwd_a), 2);
    // R2 writeback forward on operand A
    drive(1, 2, 3, 4, 0, 7, 1, 3, 1, 0);
    chk("R2 direct", int'(fwd_a), 1);
    // R3 both match: memory stage wins, on both operands
    drive(1, 2, 6, 6, 0, 6, 1, 6, 1, 0);
    chk("R3 direct a", int'(fwd_a), 2);
    chk("R3 direct b", int'(fwd_b), 2);
    // R4 operand B from writeback, A untouched
    drive(1, 2, 3, 9, 0, 0, 0, 9, 1, 0);
    chk("R4 direct b", int'(fwd_b), 1);
    chk("R4 direct a", int'(fwd_a), 0);
    // R5 register 0 and disabled writes never forward
    drive(1, 2, 0, 0, 0, 0, 1, 0, 1, 0);
    chk("R5 zero reg", int'(fwd_a), 0);
    drive(1, 2, 5, 5, 0, 5, 0, 5, 0, 0);
    chk("R5 no write", int'(fwd_b), 0);
    // R6 load-use on rs, then on rt
    drive(8, 2, 3, 8, 1, 0, 0, 0, 0, 0);
    chk("R6 rs stall", int'(stall), 1);
    chk("R6 rs pc_we", int'(pc_we), 0);
    drive(1, 8, 3, 8, 1, 0, 0, 0, 0, 0);
    chk("R6 rt ifid_we", int'(ifid_we), 0);
    // R7 only decode discarded
    chk("R7 flush_if", int'(fl_if), 0);
    chk("R7 flush_ex", int'(fl_ex), 0);
    // R8 branch with simultaneous load-use hazard
    drive(8, 2, 3, 8, 1, 0, 0, 0, 0, 1);
    chk("R8 stall", int'(stall), 0);
    chk("R8 flush_ex", int'(fl_ex), 1);
    // R9 match without memory read
    drive(8, 2, 3, 8, 0, 0, 0, 0, 0, 0);
    chk("R9 no stall", int'(stall), 0);
    // random run over a small register range
    for (int i = 0; i < 3000; i++) begin
      drive(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0) ? 1 : 0);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule